// File: doc/BRIEF.md
# Three-Level Flying-Capacitor Leg State Selector

This block turns per-leg level commands from a modulator into gate signals for a three-phase, three-level flying-capacitor converter. Each leg can sit at the low level, the high level, or the middle level. The middle level can be built from two switch combinations that give the same output voltage but push the flying-capacitor current in opposite directions. For each leg the block picks one of these two combinations once per sampling period and keeps it for that whole period. The pick uses the sign of the phase current and a flag from a comparator that says whether the capacitor sits below its half-DC-link target.

A strobe from the modulator marks the start of each period. In the strobe cycle the block makes a new pick for every leg, and that pick already applies to the command given in the same cycle. The gates are registered, so they follow the command one clock later. Each leg has two upper gates: an outer one and an inner one. The lower gates are always the complements of the upper gates. A saturating counter accumulates how many times, at a period boundary, a leg switched from one middle combination to the other. Each such change costs extra commutations.

Top module: `fc3_state_selector`

## Requirements
- R1: A leg commanded to code 0 (low level) drives its upper gate pair {outer, inner} to 2'b00 one clock after the command.
- R2: A leg commanded to code 2 (high level) drives its upper gate pair to 2'b11 one clock after the command.
- R3: A leg commanded to code 1 (middle level) drives 2'b10 for combination A or 2'b01 for combination B. The pick is B exactly when the current-positive flag differs from the capacitor-below-target flag. This gives A when charging with positive current or discharging with negative current, and B otherwise.
- R4: The pick for each leg is updated only in a cycle where period_stb is high, and the new pick applies to the command of that same cycle. Between strobes, changes of current sign or capacitor flag have no effect, so a leg never shows both 2'b10 and 2'b01 within one period.
- R5: For each leg, the lower gate pair is always the bitwise complement of the upper gate pair. For leg i, the upper pair is gate_hi[2i+1:2i] and the lower pair is gate_lo[2i+1:2i], with the outer switch in the higher bit.
- R6: The unused command code 3 is treated as the low level, so the upper gate pair goes to 2'b00.
- R7: During reset the upper gates are all 0, the lower gates are all 1, the counter is 0, and every leg's pick is A.
- R8: At each strobe, the counter grows by the number of legs whose pick changed. Without a strobe it holds its value.
- R9: The counter saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| period_stb | input | 1 | One-cycle start-of-period strobe |
| level_cmd | input | 2*NLEG | Per-leg level code, leg i at bits [2i+1:2i] |
| cur_pos | input | NLEG | Per-leg phase current sign, 1 = positive |
| cap_low | input | NLEG | Per-leg capacitor flag, 1 = below target (must charge) |
| gate_hi | output | 2*NLEG | Per-leg upper gates {outer, inner} |
| gate_lo | output | 2*NLEG | Per-leg lower gates, complements of the upper pair |
| swap_cnt | output | CNT_W | Saturating count of pick changes at period boundaries |

## Verification
Some properties are checked by assertions on every cycle. Each lower gate stays the complement of its upper gate. Code 3 and the two outer levels give their fixed patterns. A leg moves directly from one middle combination to the other only right after a strobe. The counter never decreases and stays still without a pick change. Only the bench scenarios can show the pick rule across all four combinations of current sign and capacitor flag. They also show that a pick survives input changes across non-adjacent middle-level cycles within a period, and that the count stops exactly at saturation.

// File: rtl/fc3_pkg.sv
package fc3_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_MID  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_BAD  = 2'd3
  } lvl_e;

  // upper gate pair {outer, inner} for a level and middle pick (1 = B)
  function automatic logic [1:0] upper_gates(input logic [1:0] lvl, input logic use_b);
    logic [1:0] g;
    case (lvl)
      LVL_MID:  g = use_b ? 2'b01 : 2'b10;
      LVL_HIGH: g = 2'b11;
      default:  g = 2'b00;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/fc3_pick_reg.sv
module fc3_pick_reg #(
  parameter int NLEG = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic [NLEG-1:0] cur_pos,
  input  logic [NLEG-1:0] cap_low,
  output logic [NLEG-1:0] pick_eff,
  output logic [NLEG-1:0] flip_vec
);

  logic [NLEG-1:0] pick_q;
  logic [NLEG-1:0] pick_new;
  logic [NLEG-1:0] pick_d;

  always_comb begin
    pick_new = cur_pos ^ cap_low;
    pick_d   = stb ? pick_new : pick_q;
    pick_eff = pick_d;
    flip_vec = stb ? (pick_new ^ pick_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_q <= '0;
    end else if (stb) begin
      pick_q <= pick_d;
    end
  end

  AST_PICK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(pick_q)); // R4

endmodule

// File: rtl/fc3_leg_gate.sv
module fc3_leg_gate
  import fc3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl,
  input  logic       use_b,
  output logic [1:0] hi,
  output logic [1:0] lo
);

  logic [1:0] hi_d;
  logic [1:0] lo_d;

  always_comb begin
    hi_d = upper_gates(lvl, use_b);
    lo_d = ~hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi <= 2'b00;
      lo <= 2'b11;
    end else begin
      hi <= hi_d;
      lo <= lo_d;
    end
  end

  AST_LO_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    lo == ~hi); // R5
  AST_BAD_CODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    lvl == LVL_BAD |=> hi == 2'b00); // R6
  AST_HIGH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl == LVL_HIGH |=> hi == 2'b11); // R2
  AST_LOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    lvl == LVL_LOW |=> hi == 2'b00); // R1

endmodule

// File: rtl/fc3_flip_counter.sv
module fc3_flip_counter #(
  parameter int NLEG  = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLEG-1:0]  flip_vec,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    sum = {1'b0, cnt};
    for (int i = 0; i < NLEG; i++) begin
      sum = sum + {{CNT_W{1'b0}}, flip_vec[i]};
    end
    cnt_en = |flip_vec;
    cnt_d  = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt >= $past(cnt)); // R9
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flip_vec == '0 |=> $stable(cnt)); // R8

endmodule

// File: rtl/fc3_state_selector.sv
module fc3_state_selector #(
  parameter int NLEG  = 3,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_stb,
  input  logic [2*NLEG-1:0] level_cmd,
  input  logic [NLEG-1:0]   cur_pos,
  input  logic [NLEG-1:0]   cap_low,
  output logic [2*NLEG-1:0] gate_hi,
  output logic [2*NLEG-1:0] gate_lo,
  output logic [CNT_W-1:0]  swap_cnt
);

  logic [NLEG-1:0] pick_eff;
  logic [NLEG-1:0] flip_vec;

  fc3_pick_reg #(.NLEG(NLEG)) i_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (period_stb),
    .cur_pos  (cur_pos),
    .cap_low  (cap_low),
    .pick_eff (pick_eff),
    .flip_vec (flip_vec)
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    fc3_leg_gate i_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (level_cmd[2*g+1:2*g]),
      .use_b (pick_eff[g]),
      .hi    (gate_hi[2*g+1:2*g]),
      .lo    (gate_lo[2*g+1:2*g])
    );

    AST_A_TO_B_AT_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi[2*g+1:2*g] == 2'b01 && $past(gate_hi[2*g+1:2*g]) == 2'b10)
        |-> $past(period_stb)); // R4
    AST_B_TO_A_AT_STB: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi[2*g+1:2*g] == 2'b10 && $past(gate_hi[2*g+1:2*g]) == 2'b01)
        |-> $past(period_stb)); // R4
  end

  fc3_flip_counter #(.NLEG(NLEG), .CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .flip_vec (flip_vec),
    .cnt      (swap_cnt)
  );

endmodule

// File: tb/test_fc3_state_selector.sv
module test_fc3_state_selector;

  localparam int NL = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          period_stb;
  logic [2*NL-1:0] level_cmd;
  logic [NL-1:0] cur_pos;
  logic [NL-1:0] cap_low;
  logic [2*NL-1:0] gate_hi;
  logic [2*NL-1:0] gate_lo;
  logic [CW-1:0] swap_cnt;

  int n_chk = 0;
  int n_bad = 0;
  logic [NL-1:0] m_b;
  logic [CW-1:0] m_cnt;
  logic [1:0]    seen [NL];

  always #10 clk = ~clk;

  fc3_state_selector #(.NLEG(NL), .CNT_W(CW)) i_fc3_state_selector (
    .clk(clk), .rst_n(rst_n), .period_stb(period_stb), .level_cmd(level_cmd),
    .cur_pos(cur_pos), .cap_low(cap_low), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .swap_cnt(swap_cnt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*NL-1:0] exp_hi(input logic [2*NL-1:0] l, input logic [NL-1:0] b);
    logic [2*NL-1:0] r;
    for (int i = 0; i < NL; i++) begin
      case (l[2*i+:2])
        2'd1:    r[2*i+:2] = b[i] ? 2'b01 : 2'b10;
        2'd2:    r[2*i+:2] = 2'b11;
        default: r[2*i+:2] = 2'b00;
      endcase
    end
    return r;
  endfunction

  // called at a falling edge; drives, waits one rising edge, checks mid-cycle
  task automatic apply(input logic [2*NL-1:0] l, input logic [NL-1:0] cp,
                       input logic [NL-1:0] cl, input bit s, input string req);
    logic [NL-1:0] nb;
    logic [2*NL-1:0] e;
    int sum;
    level_cmd = l; cur_pos = cp; cap_low = cl; period_stb = s;
    if (s) begin
      nb  = cp ^ cl;
      sum = int'(m_cnt) + $countones(nb ^ m_b);
      m_cnt = (sum > (2**CW - 1)) ? CW'(2**CW - 1) : CW'(sum);
      m_b = nb;
      for (int i = 0; i < NL; i++) seen[i] = 2'b00;
    end
    e = exp_hi(l, m_b);
    @(posedge clk);
    #5;
    chk(gate_hi == e, req, 32'(gate_hi), 32'(e));
    chk(gate_lo == ~e, {req, "/R5"}, 32'(gate_lo), 32'(~e));
    chk(swap_cnt == m_cnt, {req, "/R8"}, 32'(swap_cnt), 32'(m_cnt));
    for (int i = 0; i < NL; i++) begin
      if (gate_hi[2*i+:2] == 2'b10) seen[i][0] = 1'b1;
      if (gate_hi[2*i+:2] == 2'b01) seen[i][1] = 1'b1;
      chk(seen[i] != 2'b11, "R4 one middle pick per period", 32'(seen[i]), 32'd1);
    end
    @(negedge clk);
    period_stb = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; period_stb = 1'b0; level_cmd = '0; cur_pos = '0; cap_low = '0;
    m_b = '0; m_cnt = '0;
    for (int i = 0; i < NL; i++) seen[i] = 2'b00;
    repeat (3) @(negedge clk);
    chk(gate_hi == '0, "R7 reset upper", 32'(gate_hi), 32'd0);
    chk(gate_lo == '1, "R7 reset lower", 32'(gate_lo), 32'h3f);
    chk(swap_cnt == '0, "R7 reset count", 32'(swap_cnt), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    apply(6'b01_01_01, 3'b000, 3'b000, 1'b0, "R7 reset pick A");
  endtask

  task automatic t_levels;
    apply(6'b00_00_00, 3'b101, 3'b010, 1'b0, "R1 low level");
    apply(6'b10_10_10, 3'b101, 3'b010, 1'b0, "R2 high level");
    apply(6'b11_11_11, 3'b111, 3'b000, 1'b0, "R6 code 3 off");
    apply(6'b11_10_00, 3'b000, 3'b000, 1'b0, "R6 R2 R1 mixed");
  endtask

  task automatic t_rule;
    apply(6'b01_01_01, 3'b111, 3'b111, 1'b1, "R3 charge pos -> A");
    apply(6'b01_01_01, 3'b000, 3'b111, 1'b1, "R3 charge neg -> B");
    apply(6'b01_01_01, 3'b111, 3'b000, 1'b1, "R3 discharge pos -> B");
    apply(6'b01_01_01, 3'b000, 3'b000, 1'b1, "R3 discharge neg -> A");
    apply(6'b01_10_01, 3'b011, 3'b110, 1'b1, "R3 per-leg mix");
  endtask

  task automatic t_hold;
    apply(6'b01_01_01, 3'b010, 3'b000, 1'b1, "R4 strobe applies same cycle");
    apply(6'b01_01_01, 3'b101, 3'b000, 1'b0, "R4 current change ignored");
    apply(6'b10_00_10, 3'b101, 3'b111, 1'b0, "R4 outer levels between");
    apply(6'b01_01_01, 3'b000, 3'b010, 1'b0, "R4 flag change ignored");
    apply(6'b01_01_01, 3'b101, 3'b000, 1'b1, "R8 flips counted at strobe");
  endtask

  task automatic t_sat;
    for (int k = 0; k < 8; k++) begin
      apply(6'b01_01_01, (k % 2 == 0) ? 3'b000 : 3'b111, 3'b000, 1'b1, "R9 saturating count");
    end
    chk(swap_cnt == 4'hf, "R9 count stuck at max", 32'(swap_cnt), 32'hf);
    apply(6'b01_01_01, 3'b000, 3'b111, 1'b1, "R9 no wrap");
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_levels();
    t_rule();
    t_hold();
    t_sat();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule